// File: doc/BRIEF.md
# Store Buffer with Load Bypass

This block sits between one in-order processor and a memory or cache port. Stores from the processor go into a small ordered queue. The processor is released at once and does not wait for those stores to reach memory. The queue writes its entries to memory one at a time, oldest first.

Loads do not queue behind the pending stores. A load whose word address is held by no pending store goes to memory straight away, ahead of older stores. A load that matches any pending entry is held until every matching entry has been written and acknowledged. Store data is never forwarded to loads.

The memory side has one request channel shared by reads and writes, with an acknowledge that may arrive after any number of cycles. An empty flag tells a fence whether any store is still pending.

Top module: `stbuf_bypass`

## Requirements
- R1: `st_ready` is high while fewer than DEPTH (default 4) stores are pending and low when DEPTH are pending. A store is accepted on a cycle where both `st_valid` and `st_ready` are high.
- R2: Pending stores reach memory in acceptance order, with their own address and data. A write request has `mem_req_write` = 1.
- R3: A load whose address matches no pending store is sent to memory while older stores are still pending. When such a load and the oldest pending store are both ready on a cycle with no request in flight, the load takes the port.
- R4: A load whose address equals the address of any pending entry is held with `ld_ready` low until no matching entry remains. The entry being written counts as pending. The load then returns the value of the latest store to that address in program order.
- R5: An entry stays pending, and keeps its place in the address match and in the `st_ready` count, until memory acknowledges its write. A request keeps its valid, kind, address and data unchanged until `mem_ack`.
- R6: `ld_rvalid` is a one-cycle pulse on the cycle of the read's `mem_ack`, and `ld_rdata` equals `mem_rdata` on that cycle. At most one request is in flight, and `ld_ready` is low while one is.
- R7: `sb_empty` is high exactly when no store is pending.
- R8: An active-high synchronous reset empties the buffer and drops any in-flight request. After reset, `mem_req_valid` is low, `sb_empty` and `st_ready` are high, and a dropped store never reaches memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| st_valid | input | 1 | Processor offers a store |
| st_ready | output | 1 | Buffer can accept a store |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| ld_valid | input | 1 | Processor offers a load |
| ld_ready | output | 1 | Load is accepted this cycle |
| ld_addr | input | ADDR_W | Load word address |
| ld_rvalid | output | 1 | Load data valid pulse |
| ld_rdata | output | DATA_W | Load data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Request word address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Memory completes the current request |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` on a read |
| sb_empty | output | 1 | No store pending |

## Verification
Some properties are checked by assertions on every cycle:
- request stability until acknowledge, and a single request in flight;
- a load never issued while it matches a pending entry;
- the load winning a tie for the port;
- the one-cycle read pulse;
- the live-entry tally against the occupancy count;
- the reset clearing the port.

Only the bench scenarios can show the ordering results. These are the order in which writes reach memory, and the fact that every load returns the value in program order whether it bypassed or stalled. The bench sweeps acknowledge latency and queue occupancy to show them, and it also shows that a store dropped by reset never lands in memory.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

   typedef enum logic {
      REQ_READ  = 1'b0,
      REQ_WRITE = 1'b1
   } req_kind_e;

endpackage

// File: rtl/stbuf_queue.sv
// Ordered store queue with a full-width address probe over every live slot.
module stbuf_queue #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic [ADDR_W-1:0] head_addr,
   output logic [DATA_W-1:0] head_data,
   output logic              full,
   output logic              empty,
   output logic              probe_hit
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

   logic [PTR_W-1:0] head_q, tail_q, head_nx, tail_nx;
   logic [CNT_W-1:0] count_q;
   logic [ADDR_W-1:0] ent_addr [DEPTH];
   logic [DATA_W-1:0] ent_data [DEPTH];
   logic [DEPTH-1:0]  live_vec;
   logic [DEPTH-1:0]  hit_vec;

   // Pointer advance: free wrap for power-of-two depths, compare otherwise.
   if (POW2) begin : g_wrap_free
      assign head_nx = head_q + PTR_W'(1);
      assign tail_nx = tail_q + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign head_nx = (head_q == PTR_LAST) ? '0 : head_q + PTR_W'(1);
      assign tail_nx = (tail_q == PTR_LAST) ? '0 : tail_q + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         if (push) tail_q <= tail_nx;
         if (pop)  head_q <= head_nx;
         case ({push, pop})
            2'b10:   count_q <= count_q + CNT_W'(1);
            2'b01:   count_q <= count_q - CNT_W'(1);
            default: count_q <= count_q;
         endcase
      end
   end

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      localparam logic [PTR_W-1:0] SLOT = PTR_W'(gi);
      logic              live_r;
      logic [ADDR_W-1:0] addr_r;
      logic [DATA_W-1:0] data_r;

      always_ff @(posedge clk) begin
         if (rst)                           live_r <= 1'b0;
         else if (push && tail_q == SLOT)   live_r <= 1'b1;
         else if (pop && head_q == SLOT)    live_r <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (push && tail_q == SLOT) begin
            addr_r <= push_addr;
            data_r <= push_data;
         end
      end

      assign ent_addr[gi] = addr_r;
      assign ent_data[gi] = data_r;
      assign live_vec[gi] = live_r;
      assign hit_vec[gi]  = live_r && (addr_r == probe_addr);
   end

   assign head_addr = ent_addr[head_q];
   assign head_data = ent_data[head_q];
   assign full      = (count_q == CNT_FULL);
   assign empty     = (count_q == '0);
   assign probe_hit = |hit_vec;

   // R1: occupancy never passes the configured depth
   assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
      count_q <= CNT_FULL);

   // R5: a slot is released only when something is pending
   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty);

   // R7: live slots agree with the occupancy behind the empty flag
   assert_live_tally_R7: assert property (@(posedge clk) disable iff (rst)
      $countones(live_vec) == int'(count_q));

   // R2: the oldest pending store always sits at the head slot
   assert_head_live_R2: assert property (@(posedge clk) disable iff (rst)
      !empty |-> live_vec[head_q]);

endmodule

// File: rtl/stbuf_port.sv
// Single-request memory port: load-first arbitration and request register.
module stbuf_port
   import stbuf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              ld_hit,
   output logic              ld_ready,
   output logic              ld_rvalid,
   output logic [DATA_W-1:0] ld_rdata,
   input  logic              st_pending,
   input  logic [ADDR_W-1:0] head_addr,
   input  logic [DATA_W-1:0] head_data,
   output logic              pop,
   output logic              mem_req_valid,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);

   logic              busy_q;
   req_kind_e         kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              ld_go, st_go, done;

   assign ld_ready = !busy_q && !ld_hit;
   assign ld_go    = ld_valid && ld_ready;
   assign st_go    = !busy_q && !ld_go && st_pending;
   assign done     = busy_q && mem_ack;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q  <= 1'b0;
         kind_q  <= REQ_READ;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (busy_q) begin
         if (mem_ack) busy_q <= 1'b0;
      end else if (ld_go) begin
         busy_q <= 1'b1;
         kind_q <= REQ_READ;
         addr_q <= ld_addr;
      end else if (st_go) begin
         busy_q  <= 1'b1;
         kind_q  <= REQ_WRITE;
         addr_q  <= head_addr;
         wdata_q <= head_data;
      end
   end

   assign mem_req_valid = busy_q;
   assign mem_req_write = (kind_q == REQ_WRITE);
   assign mem_req_addr  = addr_q;
   assign mem_req_wdata = wdata_q;
   assign pop           = done && (kind_q == REQ_WRITE);
   assign ld_rvalid     = done && (kind_q == REQ_READ);
   assign ld_rdata      = ld_rvalid ? mem_rdata : '0;

   // R5: a request holds still until memory acknowledges it
   assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_write)
         && $stable(mem_req_addr) && $stable(mem_req_wdata)));

   // R3: a clear load beats the oldest store for an idle port
   assert_load_first_R3: assert property (@(posedge clk) disable iff (rst)
      (!mem_req_valid && ld_valid && !ld_hit && st_pending) |=>
         (mem_req_valid && !mem_req_write));

   // R4: a read never starts for an address that was pending
   assert_no_bypass_hit_R4: assert property (@(posedge clk) disable iff (rst)
      ($rose(mem_req_valid) && !mem_req_write) |-> $past(ld_valid && !ld_hit));

   // R6: load data strobe lasts a single cycle
   assert_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      ld_rvalid |=> !ld_rvalid);

   // R6: no new load while a request is in flight
   assert_one_req_R6: assert property (@(posedge clk) disable iff (rst)
      mem_req_valid |-> !ld_ready);

endmodule

// File: rtl/stbuf_bypass.sv
// Store buffer with load bypass: top level.
module stbuf_bypass #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              st_valid,
   output logic              st_ready,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic              ld_valid,
   output logic              ld_ready,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              ld_rvalid,
   output logic [DATA_W-1:0] ld_rdata,
   output logic              mem_req_valid,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              sb_empty
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("stbuf_bypass: DEPTH must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("stbuf_bypass: ADDR_W and DATA_W must be positive");
   end

   logic              q_full, q_empty, q_hit, q_push, q_pop;
   logic [ADDR_W-1:0] q_head_addr;
   logic [DATA_W-1:0] q_head_data;

   assign st_ready = !q_full;
   assign q_push   = st_valid && !q_full;
   assign sb_empty = q_empty;

   stbuf_queue #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_queue (
      .clk        (clk),
      .rst        (rst),
      .push       (q_push),
      .push_addr  (st_addr),
      .push_data  (st_data),
      .pop        (q_pop),
      .probe_addr (ld_addr),
      .head_addr  (q_head_addr),
      .head_data  (q_head_data),
      .full       (q_full),
      .empty      (q_empty),
      .probe_hit  (q_hit)
   );

   stbuf_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_port (
      .clk           (clk),
      .rst           (rst),
      .ld_valid      (ld_valid),
      .ld_addr       (ld_addr),
      .ld_hit        (q_hit),
      .ld_ready      (ld_ready),
      .ld_rvalid     (ld_rvalid),
      .ld_rdata      (ld_rdata),
      .st_pending    (!q_empty),
      .head_addr     (q_head_addr),
      .head_data     (q_head_data),
      .pop           (q_pop),
      .mem_req_valid (mem_req_valid),
      .mem_req_write (mem_req_write),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_ack       (mem_ack),
      .mem_rdata     (mem_rdata)
   );

   // R7: a write in flight means a store is still pending
   assert_empty_write_R7: assert property (@(posedge clk) disable iff (rst)
      (mem_req_valid && mem_req_write) |-> !sb_empty);

   // R8: reset leaves the port idle and the buffer empty
   assert_reset_drop_R8: assert property (@(posedge clk)
      rst |=> (!mem_req_valid && sb_empty && st_ready));

endmodule

// File: tb/stbuf_bypass_tb.sv
module stbuf_bypass_tb;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int DEPTH = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic          st_valid = 1'b0;
   logic [AW-1:0] st_addr  = '0;
   logic [DW-1:0] st_data  = '0;
   logic          st_ready;
   logic          ld_valid = 1'b0;
   logic [AW-1:0] ld_addr  = '0;
   logic          ld_ready, ld_rvalid;
   logic [DW-1:0] ld_rdata;
   logic          mem_req_valid, mem_req_write;
   logic [AW-1:0] mem_req_addr;
   logic [DW-1:0] mem_req_wdata;
   logic          mem_ack   = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic          sb_empty;

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int wait_cnt = 0;
   int cyc = 0;

   logic [DW-1:0] mem    [16];
   logic [DW-1:0] shadow [16];
   logic [AW-1:0] rq_addr [256];
   logic          rq_wr   [256];
   int            rq_n = 0;
   logic [AW-1:0] wl_addr [256];
   logic [DW-1:0] wl_data [256];
   int            wl_n = 0;
   logic [AW-1:0] ex_addr [256];
   logic [DW-1:0] ex_data [256];
   int            ex_n = 0;

   stbuf_bypass #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst(rst),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
      .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
      .ld_rvalid(ld_rvalid), .ld_rdata(ld_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .sb_empty(sb_empty)
   );

   // Memory model: acknowledges after lat extra cycles, logs requests and writes.
   always @(negedge clk) begin
      if (rst || !mem_req_valid) begin
         mem_ack  = 1'b0;
         wait_cnt = 0;
      end else begin
         if (wait_cnt == 0 && rq_n < 256) begin
            rq_addr[rq_n] = mem_req_addr;
            rq_wr[rq_n]   = mem_req_write;
            rq_n++;
         end
         if (wait_cnt >= lat) begin
            mem_ack = 1'b1;
            if (mem_req_write) begin
               mem[mem_req_addr[3:0]] = mem_req_wdata;
               if (wl_n < 256) begin
                  wl_addr[wl_n] = mem_req_addr;
                  wl_data[wl_n] = mem_req_wdata;
                  wl_n++;
               end
            end else begin
               mem_rdata = mem[mem_req_addr[3:0]];
            end
         end
         wait_cnt++;
      end
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         finish_run();
      end
   end

   task automatic check(input string req, input string what, input bit ok,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic begin_batch();
      rq_n = 0;
      wl_n = 0;
      ex_n = 0;
   endtask

   task automatic put_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      st_valid = 1'b1;
      st_addr  = a;
      st_data  = d;
      #1;
      while (!st_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      st_valid = 1'b0;
      shadow[a[3:0]] = d;
      ex_addr[ex_n] = a;
      ex_data[ex_n] = d;
      ex_n++;
   endtask

   task automatic get_load(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      ld_valid = 1'b1;
      ld_addr  = a;
      #1;
      while (!ld_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      ld_valid = 1'b0;
      do begin
         @(negedge clk);
         #1;
      end while (!ld_rvalid);
      d = ld_rdata;
   endtask

   task automatic drain_compare();
      do begin
         @(negedge clk);
         #1;
      end while (!sb_empty || mem_req_valid);
      check("R2", "write count", wl_n == ex_n, 64'(wl_n), 64'(ex_n));
      for (int i = 0; i < ex_n; i++) begin
         check("R2", "write address in order", wl_addr[i] == ex_addr[i],
               64'(wl_addr[i]), 64'(ex_addr[i]));
         check("R2", "write data in order", wl_data[i] == ex_data[i],
               64'(wl_data[i]), 64'(ex_data[i]));
      end
   endtask

   initial begin
      logic [DW-1:0] d;
      for (int i = 0; i < 16; i++) begin
         mem[i]    = 32'(i * 17 + 3);
         shadow[i] = mem[i];
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      check("R8", "st_ready after reset", st_ready == 1'b1, 64'(st_ready), 64'd1);
      check("R8", "ld_ready after reset", ld_ready == 1'b1, 64'(ld_ready), 64'd1);
      check("R7", "sb_empty after reset", sb_empty == 1'b1, 64'(sb_empty), 64'd1);
      check("R8", "no request after reset", mem_req_valid == 1'b0, 64'(mem_req_valid), 64'd0);
      check("R6", "no rvalid after reset", ld_rvalid == 1'b0, 64'(ld_rvalid), 64'd0);

      // Sweep: latency 0..3, 1..4 pending stores, loads to every address 0..7.
      for (int l = 0; l < 4; l++) begin
         for (int n = 1; n <= DEPTH; n++) begin
            lat = l;
            begin_batch();
            for (int j = 0; j < n; j++)
               put_store(32'((n * 3 + j * 5) % 8), 32'(l * 4096 + n * 256 + j * 16 + 1));
            for (int a = 0; a < 8; a++) begin
               get_load(32'(a), d);
               check("R4", "sweep load returns program-order value", d == shadow[a],
                     64'(d), 64'(shadow[a]));
            end
            drain_compare();
         end
      end

      // R3: bypass of pending stores, load wins the tie for the port.
      lat = 8;
      begin_batch();
      put_store(32'd1, 32'hA1);
      put_store(32'd2, 32'hB2);
      get_load(32'd9, d);
      check("R3", "bypass load value", d == shadow[9], 64'(d), 64'(shadow[9]));
      check("R3", "load completed with stores pending", sb_empty == 1'b0, 64'(sb_empty), 64'd0);
      check("R6", "ld_ready low while read in flight", ld_ready == 1'b0, 64'(ld_ready), 64'd0);
      @(negedge clk);
      #1;
      check("R6", "rvalid lasts one cycle", ld_rvalid == 1'b0, 64'(ld_rvalid), 64'd0);
      drain_compare();
      check("R3", "request count", rq_n == 3, 64'(rq_n), 64'd3);
      check("R3", "first request is oldest store",
            rq_wr[0] == 1'b1 && rq_addr[0] == 32'd1, 64'(rq_addr[0]), 64'd1);
      check("R3", "load ahead of second store",
            rq_wr[1] == 1'b0 && rq_addr[1] == 32'd9, 64'(rq_addr[1]), 64'd9);
      check("R3", "second store after load",
            rq_wr[2] == 1'b1 && rq_addr[2] == 32'd2, 64'(rq_addr[2]), 64'd2);

      // R4: load matching the younger pending entry waits for it to drain.
      lat = 5;
      begin_batch();
      put_store(32'd6, 32'hC6);
      put_store(32'd7, 32'hD7);
      get_load(32'd7, d);
      check("R4", "stalled load value", d == 32'hD7, 64'(d), 64'hD7);
      check("R7", "empty once matching store drained", sb_empty == 1'b1, 64'(sb_empty), 64'd1);
      drain_compare();
      check("R4", "request count", rq_n == 3, 64'(rq_n), 64'd3);
      check("R4", "both writes before the read",
            rq_wr[0] == 1'b1 && rq_wr[1] == 1'b1 && rq_addr[1] == 32'd7,
            64'(rq_addr[1]), 64'd7);
      check("R4", "read issued last", rq_wr[2] == 1'b0 && rq_addr[2] == 32'd7,
            64'(rq_wr[2]), 64'd0);

      // R1 and R5: full buffer, slot freed only by the write acknowledge.
      lat = 30;
      begin_batch();
      for (int j = 0; j < DEPTH; j++)
         put_store(32'(10 + j), 32'(32'h100 + j));
      check("R1", "st_ready low when full", st_ready == 1'b0, 64'(st_ready), 64'd0);
      check("R7", "sb_empty low with stores pending", sb_empty == 1'b0, 64'(sb_empty), 64'd0);
      do begin
         @(negedge clk);
         #1;
      end while (!mem_ack);
      check("R5", "slot still held on ack cycle", st_ready == 1'b0, 64'(st_ready), 64'd0);
      @(negedge clk);
      #1;
      check("R1", "st_ready back after ack", st_ready == 1'b1, 64'(st_ready), 64'd1);
      put_store(32'd5, 32'h555);
      drain_compare();

      // R8: reset in the middle of a write drops it and the pending stores.
      lat = 40;
      begin_batch();
      put_store(32'd14, 32'hEE);
      put_store(32'd15, 32'hFF);
      repeat (3) @(negedge clk);
      #1;
      check("R5", "write held while waiting", mem_req_valid == 1'b1 && mem_req_write == 1'b1,
            64'(mem_req_valid), 64'd1);
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      #1;
      check("R8", "empty after mid reset", sb_empty == 1'b1, 64'(sb_empty), 64'd1);
      check("R8", "request dropped", mem_req_valid == 1'b0, 64'(mem_req_valid), 64'd0);
      check("R8", "st_ready after mid reset", st_ready == 1'b1, 64'(st_ready), 64'd1);
      repeat (3) @(negedge clk);
      #1;
      check("R8", "no request reissued", mem_req_valid == 1'b0, 64'(mem_req_valid), 64'd0);
      for (int i = 0; i < 16; i++) shadow[i] = mem[i];
      lat = 1;
      get_load(32'd14, d);
      check("R8", "dropped store never written", d == 32'(14 * 17 + 3), 64'(d),
            64'(14 * 17 + 3));

      finish_run();
   end
endmodule